// File: doc/BRIEF.md
# Prefixed Base32 Identifier Decoder

This block takes a 32-character ASCII identifier and turns it into a packed 16-byte result. An identifier is valid when its first eight characters spell `did:plc:` and each of the 24 characters after them is a lowercase letter or a digit from 2 to 7. Each of those 24 characters carries a 5-bit value. The block packs the 120 bits most-significant-first behind a leading status byte that reads zero only when every check passed.

An identifier arrives in one of two ways on the same 256-bit input. In the first, the whole identifier comes in a single transfer. In the second, it comes as four 8-byte beats on the low 64 bits: the prefix first, then the three payload groups. Both input and output use a valid/ready handshake. The result is held until the consumer takes it, and no new input is accepted in the meantime. The character conversion is done without branching on validity, so on a failure only the status byte carries meaning.

Top module: `b32_id_decoder`

## Requirements
- R1: Within an identifier the first character is the most significant byte. The first eight characters must equal ASCII `did:plc:` (0x64 0x69 0x64 0x3A 0x70 0x6C 0x63 0x3A). Any mismatch makes the status byte 0x01.
- R2: Each of the 24 payload characters must lie in 0x61..0x7A or 0x32..0x37. Any other byte, including uppercase letters, 0x31, 0x38, 0x60 and 0x7B, makes the status byte 0x01.
- R3: A letter decodes to its code minus 0x61 (values 0 to 25). A digit decodes to its code minus 0x18 (values 26 to 31).
- R4: The 24 values are packed first-character-first into `outData[119:0]`, with the first value in bits 119:115. Byte 1 (`outData[119:112]`) therefore holds the first value followed by the top 3 bits of the second value.
- R5: The status byte `outData[127:120]` is 0x00 when the prefix and all payload characters are valid, and 0x01 otherwise. When it is 0x00, `outData[119:0]` is the exact packing from R4.
- R6: Whole-word mode: an accepted transfer with `inWide`=1 while no beats are pending delivers the full identifier, first character at `inData[255:248]`. `outValid` is high in the cycle after the accepting edge.
- R7: Beat mode: four accepted transfers with `inWide`=0 deliver the identifier 8 characters at a time on `inData[63:0]`, first character at bits 63:56, and `inData[255:64]` is ignored. `outValid` rises in the cycle after the fourth beat, never earlier. A failure in any beat sets the status byte, even when the later beats are valid.
- R8: While `outValid` is high and `outReady` is low, `outValid` stays high, `outData` stays stable, `inReady` is low, and any offered input is not taken.
- R9: In the cycle after the output handshake, `outValid` is low and `inReady` is high, and a new identifier is accepted.
- R10: A synchronous reset drops `outValid`, raises `inReady`, discards any partly received beats, and leaves the status byte at 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input transfer offered |
| inReady | output | 1 | Block can take an input transfer |
| inWide | input | 1 | 1: whole identifier in this transfer; 0: one 8-byte beat |
| inData | input | 256 | Identifier (whole-word) or beat in bits 63:0 |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result |
| outData | output | 128 | Status byte in 127:120, packed values in 119:0 |

## Verification
The bench targets the edges of the character ranges: 0x31 and 0x38 just outside the digits, 0x60 and 0x7B just outside the letters, and uppercase letters. A design whose range compares were off by one would report such identifiers as valid. It runs every identifier in both input modes, with garbage in the upper 192 bits during beats, and includes cases where only a middle beat is bad. These catch a validity accumulator that is overwritten instead of ANDed, and a beat lane that reads the wrong bits. It also checks the bit order of byte 1 and byte 2, which catches a swapped or misaligned packing. Backpressure with an input offered while the result waits, and a reset between beats, expose a beat counter that advances when it should not or survives reset.

// File: rtl/b32_id_pkg.sv
package b32_id_pkg;
  localparam int CHAR_W      = 8;
  localparam int GROUP_CHARS = 8;
  localparam int NUM_GROUPS  = 4;   // one prefix group plus payload groups
  localparam int SYM_W       = 5;
  localparam int DISC_W      = 8;

  localparam int GROUP_W    = CHAR_W * GROUP_CHARS;
  localparam int ID_W       = GROUP_W * NUM_GROUPS;
  localparam int PAY_GROUPS = NUM_GROUPS - 1;
  localparam int VAL_W      = SYM_W * GROUP_CHARS;
  localparam int PACK_W     = VAL_W * PAY_GROUPS;
  localparam int OUT_W      = PACK_W + DISC_W;
  localparam int CNT_W      = $clog2(NUM_GROUPS);

  localparam logic [GROUP_W-1:0] PREFIX_WORD = 64'h6469_643a_706c_633a;
  localparam logic [DISC_W-1:0]  DISC_OK     = 8'h00;
  localparam logic [DISC_W-1:0]  DISC_BAD    = 8'h01;

  typedef struct packed {
    logic                  loadWide;
    logic [NUM_GROUPS-1:0] loadBeat;   // one-hot beat index, 0 = prefix
  } strobe_t;
endpackage

// File: rtl/b32_group_decode.sv
module b32_group_decode
  import b32_id_pkg::*;
(
  input  logic [GROUP_W-1:0] chars,
  output logic [VAL_W-1:0]   vals,
  output logic               ok
);
  logic [GROUP_CHARS-1:0] charOk;

  for (genvar i = 0; i < GROUP_CHARS; i++) begin : g_char
    logic [CHAR_W-1:0] c;
    logic isLetter, isDigit;
    assign c        = chars[GROUP_W-1-i*CHAR_W -: CHAR_W];
    assign isLetter = (c >= 8'h61) && (c <= 8'h7a);
    assign isDigit  = (c >= 8'h32) && (c <= 8'h37);
    assign charOk[i] = isLetter | isDigit;
    // low five bits of the offsets 0x61 and 0x18; the subtraction wraps mod 32
    assign vals[VAL_W-1-i*SYM_W -: SYM_W] =
      c[6] ? (c[SYM_W-1:0] - 5'h01) : (c[SYM_W-1:0] - 5'h18);
  end

  assign ok = &charOk;
endmodule

// File: rtl/b32_id_datapath.sv
module b32_id_datapath
  import b32_id_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strb,
  input  logic [ID_W-1:0]  inData,
  output logic [OUT_W-1:0] outData
);
  logic [GROUP_W-1:0] lane [NUM_GROUPS];
  logic [VAL_W-1:0]   payVal [PAY_GROUPS];
  logic [PAY_GROUPS-1:0] payOk;
  logic prefixOk, allOk;
  logic [PACK_W-1:0] packReg;
  logic okReg;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lane
    assign lane[g] = strb.loadWide ? inData[ID_W-1-g*GROUP_W -: GROUP_W]
                                   : inData[GROUP_W-1:0];
  end

  assign prefixOk = (lane[0] == PREFIX_WORD);

  for (genvar g = 0; g < PAY_GROUPS; g++) begin : g_pay
    b32_group_decode u_dec (
      .chars(lane[g+1]),
      .vals (payVal[g]),
      .ok   (payOk[g])
    );
  end

  assign allOk = prefixOk & (&payOk);

  always_ff @(posedge clk) begin
    if (rst) begin
      packReg <= '0;
      okReg   <= 1'b0;
    end else if (strb.loadWide) begin
      for (int g = 0; g < PAY_GROUPS; g++)
        packReg[PACK_W-1-g*VAL_W -: VAL_W] <= payVal[g];
      okReg <= allOk;
    end else begin
      if (strb.loadBeat[0]) okReg <= prefixOk;
      for (int g = 0; g < PAY_GROUPS; g++) begin
        if (strb.loadBeat[g+1]) begin
          packReg[PACK_W-1-g*VAL_W -: VAL_W] <= payVal[g];
          okReg <= okReg & payOk[g];
        end
      end
    end
  end

  assign outData = {(okReg ? DISC_OK : DISC_BAD), packReg};
endmodule

// File: rtl/b32_id_control.sv
module b32_id_control
  import b32_id_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  input  logic    inWide,
  input  logic    outReady,
  output logic    inReady,
  output logic    outValid,
  output strobe_t strb
);
  logic [CNT_W-1:0] beatCount;
  logic accept, wideStart, beatTake, lastBeat;

  assign inReady   = !outValid;
  assign accept    = inValid && inReady;
  assign wideStart = accept && inWide && (beatCount == '0);
  assign beatTake  = accept && !wideStart;
  assign lastBeat  = (beatCount == CNT_W'(NUM_GROUPS - 1));

  always_comb begin
    strb.loadWide = wideStart;
    for (int g = 0; g < NUM_GROUPS; g++)
      strb.loadBeat[g] = beatTake && (beatCount == CNT_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beatCount <= '0;
      outValid  <= 1'b0;
    end else begin
      if (outValid && outReady) outValid <= 1'b0;
      if (wideStart) begin
        outValid <= 1'b1;
      end else if (beatTake) begin
        if (lastBeat) begin
          beatCount <= '0;
          outValid  <= 1'b1;
        end else begin
          beatCount <= beatCount + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/b32_id_decoder.sv
module b32_id_decoder
  import b32_id_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic             inWide,
  input  logic [ID_W-1:0]  inData,
  output logic             outValid,
  input  logic             outReady,
  output logic [OUT_W-1:0] outData
);
  strobe_t strb;

  b32_id_control u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inWide  (inWide),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strb    (strb)
  );

  b32_id_datapath u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .inData (inData),
    .outData(outData)
  );
endmodule

// File: rtl/b32_id_decoder_chk.sv
module b32_id_decoder_chk
  import b32_id_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inReady,
  input logic             inWide,
  input logic             outValid,
  input logic             outReady,
  input logic [OUT_W-1:0] outData
);
  logic [CNT_W-1:0] seen;
  logic take, wideGo, lastGo;

  assign take   = inValid && inReady;
  assign wideGo = take && inWide && (seen == '0);
  assign lastGo = take && !wideGo && (seen == CNT_W'(NUM_GROUPS - 1));

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (take && !wideGo) seen <= lastGo ? '0 : seen + 1'b1;
  end

  assert_wide_latency_R6: assert property (@(posedge clk) disable iff (rst)
    wideGo |=> outValid);
  assert_beat_latency_R7: assert property (@(posedge clk) disable iff (rst)
    lastGo |=> outValid);
  assert_no_early_result_R7: assert property (@(posedge clk) disable iff (rst)
    (take && !wideGo && !lastGo) |=> !outValid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
  assert_block_input_R8: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !inReady);
  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady) |=> (!outValid && inReady));
  assert_status_code_R5: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outData[OUT_W-1 -: DISC_W] == DISC_OK ||
                  outData[OUT_W-1 -: DISC_W] == DISC_BAD));
endmodule

bind b32_id_decoder b32_id_decoder_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .inReady (inReady),
  .inWide  (inWide),
  .outValid(outValid),
  .outReady(outReady),
  .outData (outData)
);

// File: tb/b32_id_decoder_test.sv
`timescale 1ns/1ps
module b32_id_decoder_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic         inReady;
  logic         inWide = 1'b0;
  logic [255:0] inData = '0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [127:0] outData;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  b32_id_decoder uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inWide(inWide), .inData(inData), .outValid(outValid),
    .outReady(outReady), .outData(outData)
  );

  localparam int NV = 12;
  localparam logic [255:0] VEC [NV] = '{
    {"did:plc:", "aaaaaaaa", "aaaaaaaa", "aaaaaaaa"},
    {"did:plc:", "77777777", "77777777", "77777777"},
    {"did:plc:", "abcdefgh", "ijklmnop", "qrstuvwx"},
    {"did:plc:", "234567zy", "xwvutsrq", "ponmlkji"},
    {"did:plx:", "aaaaaaaa", "aaaaaaaa", "aaaaaaaa"},
    {"did:plc:", "aaaaaaaa", "aaaaaaa1", "aaaaaaaa"},
    {"did:plc:", "aaaaaaaa", "aaaaaaaa", "8aaaaaaa"},
    {"did:plc:", "aaaa{aaa", "aaaaaaaa", "aaaaaaaa"},
    {"did:plc:", "abcdefgh", "`bcdefgh", "zzzzzzzz"},
    {"did:plc:", "zzzzzzzz", "zzzzzzzz", "Aaaaaaaa"},
    {"DID:PLC:", "aaaaaaaa", "aaaaaaaa", "aaaaaaaa"},
    {"did:plc:", "zzzzzzzz", "22222222", "mnbvcxqw"}
  };
  localparam bit EXP_OK [NV] = '{1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1};

  // expected packing built from the character rules
  function automatic logic [119:0] refPack(input logic [255:0] id);
    logic [119:0] acc = '0;
    for (int i = 0; i < 24; i++) begin
      logic [7:0] c = id[191 - 8*i -: 8];
      logic [7:0] v = (c >= 8'h61) ? c - 8'h61 : c - 8'h18;
      acc = {acc[114:0], v[4:0]};
    end
    return acc;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [255:0] d, input logic wide);
    int n = 0;
    while (!inReady && n < 50) begin @(negedge clk); n++; end
    if (!inReady) check("R8 input stall", 0, 1);
    inValid = 1'b1; inData = d; inWide = wide;
    @(negedge clk);
    inValid = 1'b0; inWide = 1'b0;
  endtask

  task automatic sendId(input logic [255:0] id, input logic wide, input string req);
    if (wide) sendWord(id, 1'b1);
    else for (int k = 0; k < 4; k++) begin
      if (k == 3) check({req, " no early result"}, {127'd0, outValid}, 128'd0);
      sendWord({{192{1'b1}}, id[255 - 64*k -: 64]}, 1'b0);
    end
    check({req, " result latency"}, {127'd0, outValid}, 128'd1);
  endtask

  task automatic takeResult(output logic [127:0] res);
    int n = 0;
    while (!outValid && n < 50) begin @(negedge clk); n++; end
    res = outData;
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check("R9 release after handshake", {126'd0, outValid, inReady}, 128'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] res, held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check("R10 outValid after reset", {127'd0, outValid}, 128'd0);
    check("R10 inReady after reset", {127'd0, inReady}, 128'd1);
    check("R10 status after reset", {120'd0, outData[127:120]}, 128'h01);

    // table walk, both modes (R1, R2, R3, R4, R5, R6, R7)
    for (int v = 0; v < NV; v++) begin
      for (int m = 0; m < 2; m++) begin
        string req = (m == 1) ? "R6" : "R7";
        sendId(VEC[v], m[0], req);
        takeResult(res);
        if (EXP_OK[v])
          check({req, " R3 R4 R5 valid decode"}, res, {8'h00, refPack(VEC[v])});
        else
          check({req, " R1 R2 R5 invalid status"}, {120'd0, res[127:120]}, 128'h01);
      end
    end

    // R4: bit order across bytes 1 and 2
    sendId({"did:plc:", "a7aaaaaa", "aaaaaaaa", "aaaaaaaa"}, 1'b1, "R6");
    takeResult(res);
    check("R4 byte1/byte2 order", {112'd0, res[119:104]}, 128'h07C0);
    // R3: digit and letter boundaries
    sendId({"did:plc:", "2aaaaaaa", "aaaaaaaa", "aaaaaaa7"}, 1'b0, "R7");
    takeResult(res);
    check("R3 digit 2 is 26", {120'd0, res[119:112]}, 128'hD0);
    check("R3 last value 31", {123'd0, res[4:0]}, 128'h1F);
    sendId({"did:plc:", "zaaaaaaa", "aaaaaaaa", "aaaaaaaa"}, 1'b1, "R6");
    takeResult(res);
    check("R3 letter z is 25", {120'd0, res[119:112]}, 128'hC8);

    // R8: backpressure with an offered input
    sendId(VEC[2], 1'b1, "R6");
    held = outData;
    inValid = 1'b1; inWide = 1'b0; inData = {"did:plx:", "zzzzzzzz", "zzzzzzzz", "zzzzzzzz"};
    repeat (3) @(negedge clk);
    inValid = 1'b0;
    check("R8 outValid held", {126'd0, outValid, inReady}, 128'd2);
    check("R8 outData stable", outData, held);
    takeResult(res);
    sendId(VEC[3], 1'b0, "R7");
    takeResult(res);
    check("R8 stalled input not taken", res, {8'h00, refPack(VEC[3])});

    // R10: reset between beats discards partial identifier
    sendWord({192'd0, "did:plx:"}, 1'b0);
    sendWord({192'd0, "11111111"}, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 mid-beat reset clears", {126'd0, outValid, inReady}, 128'd1);
    sendId(VEC[11], 1'b0, "R7");
    takeResult(res);
    check("R10 decode after mid-beat reset", res, {8'h00, refPack(VEC[11])});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule